// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog that escalates in two steps. When the count first runs out, it sets an interrupt status bit and starts counting down again from the load value. If the count runs out a second time while that status bit is still set, and resets are enabled, it sends a one-cycle reset request to the chip's reset controller.

Software controls the block through a small word-wide register port. Writes happen on a clock edge when `we_i` is high. Reads are combinational from `addr_i`.

Software services the watchdog by writing to the clear address. That write drops the pending status and restarts the count. Software starts the counter by setting the interrupt-enable bit. After that, only a hardware reset can stop the counter.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the load register and the counter both read all ones, the control register reads 0, the status register reads 0, and `irq_o` and `rst_req_o` are low.
- R2: Control register (address 2): bit 0 is the run/interrupt enable and bit 1 is the reset enable. While bit 0 is clear, the counter holds its value. Once bit 0 is written as 1, writing 0 to it leaves it set; only `rst_ni` clears it. Bit 1 can be written either way at any time.
- R3: While running, the counter (readable at address 1) drops by one on each clock. A write to the load register (address 0) puts the written value into both the load register and the counter at that edge, whether or not the counter is running.
- R4: A running counter that reads 0 expires on the next edge. At that edge, status bit 0 (raw pending, address 4) is set and the counter reloads from the load register.
- R5: Status bit 1 (masked pending) and `irq_o` both equal raw pending AND the run/interrupt enable.
- R6: When the counter expires while raw pending is already set, `rst_req_o` is high for the cycle after that edge, but only if the reset enable is set. The counter reloads and raw pending stays set. With the reset enable clear, `rst_req_o` stays low.
- R7: Any write to address 3 clears raw pending and reloads the counter from the load register. Address 3 reads as 0.
- R8: If a write to address 0 or address 3 lands on the same edge as an expiry, the write wins. No expiry is recorded, raw pending does not become set, and no reset request is issued.
- R9: A load value of 0 makes the counter expire on every running clock edge. The first edge sets raw pending, and each later edge issues a reset request if resets are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i` |
| irq_o | output | 1 | Masked time-out interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two functions can fall on the same edge: a software service (a clear write or a load write) and a counter expiry. The bench provokes this by timing the write strobe so its edge is exactly the edge on which the counter would leave zero. It does this in both stages: before the interrupt is pending, and again while it is pending with resets enabled. At the ports, the bench then expects raw pending to be unchanged or cleared, no reset pulse, and the counter holding the reloaded value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 3'd0,
    A_COUNT = 3'd1,
    A_CTRL  = 3'd2,
    A_CLEAR = 3'd3,
    A_STAT  = 3'd4
  } wdt_addr_e;

  typedef struct packed {
    logic rst_en;
    logic int_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  output logic [CNT_W-1:0]  load_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              load_wr_o,
  output logic              clr_wr_o,
  output logic [CNT_W-1:0]  rdata_o
);
  wdt_addr_e addr;
  assign addr      = wdt_addr_e'(addr_i);
  assign load_wr_o = we_i && (addr == A_LOAD);
  assign clr_wr_o  = we_i && (addr == A_CLEAR);

  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '1;
      ctrl_o <= '0;
    end else begin
      if (load_wr_o) load_o <= wdata_i;
      if (ctrl_wr) begin
        ctrl_o.int_en <= ctrl_o.int_en | wdata_i[0];  // sticky until reset
        ctrl_o.rst_en <= wdata_i[1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_LOAD:  rdata_o = load_o;
      A_COUNT: rdata_o = cnt_i;
      A_CTRL:  rdata_o[1:0] = {ctrl_o.rst_en, ctrl_o.int_en};
      A_STAT:  rdata_o[1:0] = {raw_i & ctrl_o.int_en, raw_i};
      default: rdata_o = '0;
    endcase
  end

  // R2
  int_en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.int_en |=> ctrl_o.int_en);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic at_zero;
  assign at_zero  = (cnt_o == '0);
  // a software reload on the same edge cancels the expiry
  assign expire_o = run_i && at_zero && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '1;
    else if (reload_i) cnt_o <= reload_val_i;
    else if (expire_o) cnt_o <= load_val_i;
    else if (run_i)    cnt_o <= cnt_o - 1'b1;
  end

  // R3
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_o == $past(reload_val_i));
  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !reload_i && !at_zero) |=> cnt_o == $past(cnt_o) - 1'b1);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic int_en_i,
  input  logic rst_en_i,
  output logic raw_o,
  output logic irq_o,
  output logic rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_i && raw_o && rst_en_i;
      if (clr_i)         raw_o <= 1'b0;
      else if (expire_i) raw_o <= 1'b1;
    end
  end

  assign irq_o = raw_o & int_en_i;

  // R6
  rst_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(raw_o) && $past(rst_en_i) && raw_o);
  // R4
  raw_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o) |-> $past(expire_i));
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !raw_o && !rst_req_o);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] load_q, cnt, reload_val;
  wdt_ctrl_t        ctrl;
  logic             load_wr, clr_wr, expire, raw;

  wdt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .raw_i(raw),
    .load_o(load_q), .ctrl_o(ctrl),
    .load_wr_o(load_wr), .clr_wr_o(clr_wr), .rdata_o
  );

  assign reload_val = load_wr ? wdata_i : load_q;

  wdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i, .rst_ni,
    .run_i(ctrl.int_en),
    .reload_i(load_wr | clr_wr),
    .reload_val_i(reload_val),
    .load_val_i(load_q),
    .cnt_o(cnt),
    .expire_o(expire)
  );

  wdt_stage i_stage (
    .clk_i, .rst_ni,
    .expire_i(expire), .clr_i(clr_wr),
    .int_en_i(ctrl.int_en), .rst_en_i(ctrl.rst_en),
    .raw_o(raw), .irq_o, .rst_req_o
  );

  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw && ctrl.int_en);
endmodule

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic irq, rst_req;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wdt_two_stage #(.CNT_W(W)) i_wdt_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] v;
    #20; rst_n = 1'b1; #1;
    // R1 reset state
    rd(3'd0, v); chk("R1 load", v, '1);
    rd(3'd1, v); chk("R1 count", v, '1);
    rd(3'd2, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);

    // R2 hold while disabled; R3 load writes while stopped
    repeat (3) tick();
    rd(3'd1, v); chk("R2 hold after reset", v, '1);
    wr(3'd0, 5);
    rd(3'd1, v); chk("R3 load while stopped", v, 5);
    repeat (3) tick();
    rd(3'd1, v); chk("R2 hold stopped", v, 5);
    wr(3'd2, 1);
    rd(3'd1, v); chk("R2 enable edge", v, 5);
    tick(); tick();
    rd(3'd1, v); chk("R3 count down", v, 3);
    wr(3'd2, 2);
    rd(3'd2, v); chk("R2 enable sticky", v, 3);
    wr(3'd2, 0);
    rd(3'd2, v); chk("R2 rst_en clears", v, 1);

    // R4 R5 R6 R9 sweep over load and reset enable
    for (int re = 0; re < 2; re++) begin
      wr(3'd2, W'(1 + 2*re));
      for (int l = 0; l < 8; l++) begin
        wr(3'd3, 0);
        wr(3'd0, W'(l));
        repeat (l) tick();
        rd(3'd1, v); chk("R3 reaches zero", v, 0);
        rd(3'd4, v); chk("R4 not yet pending", v, 0);
        tick();
        rd(3'd4, v); chk("R4 R5 first expiry status", v, 3);
        chk("R5 irq", irq, 1);
        chk("R9 R4 no reset on first", rst_req, 0);
        rd(3'd1, v); chk("R4 reload", v, W'(l));
        repeat (l) tick();
        chk("R6 no early reset", rst_req, 0);
        tick();
        chk("R6 R9 second expiry reset", rst_req, W'(re));
        rd(3'd4, v); chk("R6 still pending", v, 3);
        rd(3'd1, v); chk("R6 reload", v, W'(l));
        tick();
        chk("R6 R9 pulse after", rst_req, (l == 0) ? W'(re) : 0);
      end
    end

    // R7 clear; R8 collisions (reset enabled)
    wr(3'd2, 3);
    wr(3'd3, 0);
    rd(3'd4, v); chk("R7 clear status", v, 0);
    rd(3'd3, v); chk("R7 clear reads zero", v, 0);
    wr(3'd0, 4);
    repeat (4) tick();
    wr(3'd3, 0);  // lands on first expiry edge
    rd(3'd4, v); chk("R8 clear vs first expiry", v, 0);
    rd(3'd1, v); chk("R8 clear reload", v, 4);
    repeat (4) tick();
    tick();
    rd(3'd4, v); chk("R4 pending again", v, 3);
    repeat (4) tick();
    wr(3'd3, 0);  // lands on second expiry edge
    chk("R8 no reset on clear collision", rst_req, 0);
    rd(3'd4, v); chk("R8 pending cleared", v, 0);
    repeat (4) tick();
    tick();
    repeat (4) tick();
    wr(3'd0, 6);  // load write on second expiry edge
    chk("R8 no reset on load collision", rst_req, 0);
    rd(3'd4, v); chk("R8 pending kept", v, 3);
    rd(3'd1, v); chk("R8 load wins", v, 6);
    tick();
    chk("R6 stays low", rst_req, 0);
    summary();
  end
endmodule